// File: doc/BRIEF.md
# Lockable pad attribute register bank

This block is a configuration bank on a plain 32-bit register port. It keeps one attribute byte for every pad in two groups, dedicated and muxed, and drives each byte to the pad ring. Each attribute byte controls these pad features:

- signal inversion
- virtual open-drain
- pull-down and pull-up
- keeper
- weak drive

When software writes a pad's register, the block pulses that pad's update strobe for one cycle. The pulse comes in the same cycle as the new byte, so pad-side logic can use it as a load qualifier.

Software writes do not store raw data. The block keeps only the attribute bits that a parameter mask marks as implemented. It also resolves a write that asks for both pull directions: the pull-up is kept and the pull-down is cleared. The bank also has a lock bit that can only be cleared. Once software clears it, every attribute register is frozen until the next reset.

The register port has no back-pressure. Every access completes in the cycle it is presented. Read data is a combinational function of the address, and a write takes effect at the next rising clock edge.

Top module: `padattr_bank`

## Requirements
- R1: After reset the lock word reads 1, every attribute byte and every readback reads 0, and no update strobe is high.
- R2: Writing a word with bit 0 clear to word address 0 clears the lock bit. Writing bit 0 set has no effect. Once clear, the lock bit stays 0 until reset.
- R3: While the lock bit is 0, writes to any attribute register leave the stored byte unchanged and raise no update strobe.
- R4: Word address 0 holds the lock bit in bit 0. Addresses 1 to NUM_DED hold the dedicated pads in order. The next NUM_MUX addresses hold the muxed pads. Attribute reads return the byte in bits 7:0 with bits 31:8 zero. Any other address reads 0, and a write to it changes nothing.
- R5: The stored byte is write data bits 7:0 ANDed with ATTR_MASK. Bits 7:6 are never implemented. The default mask is 0x3F. Bit meanings are: 0 inversion, 1 open-drain, 2 pull-down, 3 pull-up, 4 keeper, 5 weak drive.
- R6: If a write sets both bit 3 and bit 2 after masking, bit 2 is stored as 0.
- R7: An accepted attribute write raises exactly the written pad's strobe for the single cycle after the write edge. The new byte appears on the pad output in that same cycle. An attribute output changes only when its strobe is high.
- R8: Each pad's attribute output equals the value read back from that pad's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ded_attr | output | NUM_DED*8 | Dedicated pad attribute bytes, pad i in bits 8i+7:8i |
| ded_upd | output | NUM_DED | Dedicated pad update strobes |
| mux_attr | output | NUM_MUX*8 | Muxed pad attribute bytes, pad i in bits 8i+7:8i |
| mux_upd | output | NUM_MUX | Muxed pad update strobes |

## Verification
The assertions check four rules on every cycle:

- the lock bit never returns to 1 after it clears;
- no strobe follows a cycle spent locked;
- at most one strobe is high;
- no pad byte ever holds an unimplemented bit or both pull directions, and a pad byte moves only under its strobe.

Only the bench scenarios can show the remaining behaviour:

- the address map and the zero readback from unmapped words;
- the exact stored values after masking and pull resolution;
- that writing 1 to the lock word leaves it unchanged;
- that a locked write keeps the old byte.

// File: rtl/padattr_pkg.sv
package padattr_pkg;
  localparam int ATTR_W   = 8;
  localparam int BIT_INV  = 0;
  localparam int BIT_OD   = 1;
  localparam int BIT_PD   = 2;
  localparam int BIT_PU   = 3;
  localparam int BIT_KEEP = 4;
  localparam int BIT_WEAK = 5;
  localparam logic [ATTR_W-1:0] LEGAL_BITS = 8'h3F;

  typedef logic [ATTR_W-1:0] attr_t;
endpackage

// File: rtl/padattr_legalize.sv
module padattr_legalize
  import padattr_pkg::*;
#(
  parameter logic [7:0] ATTR_MASK = 8'h3F
) (
  input  attr_t raw,
  output attr_t legal
);
  localparam attr_t EFF_MASK = ATTR_MASK & LEGAL_BITS;

  attr_t masked;

  always_comb begin
    masked = raw & EFF_MASK;
    legal  = masked;
    if (masked[BIT_PU] && masked[BIT_PD]) begin
      legal[BIT_PD] = 1'b0;
    end
  end
endmodule

// File: rtl/padattr_lock.sv
module padattr_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic open_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
    end else if (wr && !wbit) begin
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/padattr_group.sv
module padattr_group
  import padattr_pkg::*;
#(
  parameter int NUM    = 8,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     idx,
  input  attr_t                 wr_val,
  output attr_t                 rd_val,
  output logic [NUM*ATTR_W-1:0] attr_flat,
  output logic [NUM-1:0]        upd
);
  attr_t           attr_q [NUM];
  logic  [NUM-1:0] upd_q;

  for (genvar i = 0; i < NUM; i++) begin : g_pad
    logic hit;
    assign hit = wr_en && (idx == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attr_q[i] <= '0;
        upd_q[i]  <= 1'b0;
      end else begin
        upd_q[i] <= hit;
        if (hit) begin
          attr_q[i] <= wr_val;
        end
      end
    end

    assign attr_flat[i*ATTR_W +: ATTR_W] = attr_q[i];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == ADDR_W'(i)) rd_val = attr_q[i];
    end
  end

  assign upd = upd_q;
endmodule

// File: rtl/padattr_bank.sv
module padattr_bank
  import padattr_pkg::*;
#(
  parameter int         NUM_DED   = 15,
  parameter int         NUM_MUX   = 32,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] ATTR_MASK = 8'h3F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_DED*ATTR_W-1:0] ded_attr,
  output logic [NUM_DED-1:0]        ded_upd,
  output logic [NUM_MUX*ATTR_W-1:0] mux_attr,
  output logic [NUM_MUX-1:0]        mux_upd
);
  localparam int DED_BASE = 1;
  localparam int MUX_BASE = DED_BASE + NUM_DED;
  localparam int MAP_END  = MUX_BASE + NUM_MUX;

  logic              lock_q;
  logic              hit_lock, hit_ded, hit_mux;
  logic [ADDR_W-1:0] ded_idx, mux_idx;
  attr_t             wr_legal, ded_rd, mux_rd;

  assign hit_lock = (bus_addr == '0);
  assign hit_ded  = (bus_addr >= ADDR_W'(DED_BASE)) && (bus_addr < ADDR_W'(MUX_BASE));
  assign hit_mux  = (bus_addr >= ADDR_W'(MUX_BASE)) && (bus_addr < ADDR_W'(MAP_END));
  assign ded_idx  = bus_addr - ADDR_W'(DED_BASE);
  assign mux_idx  = bus_addr - ADDR_W'(MUX_BASE);

  padattr_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_we && hit_lock),
    .wbit   (bus_wdata[0]),
    .open_q (lock_q)
  );

  padattr_legalize #(.ATTR_MASK(ATTR_MASK)) u_legal (
    .raw   (bus_wdata[ATTR_W-1:0]),
    .legal (wr_legal)
  );

  padattr_group #(.NUM(NUM_DED), .ADDR_W(ADDR_W)) u_ded (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we && lock_q && hit_ded),
    .idx       (ded_idx),
    .wr_val    (wr_legal),
    .rd_val    (ded_rd),
    .attr_flat (ded_attr),
    .upd       (ded_upd)
  );

  padattr_group #(.NUM(NUM_MUX), .ADDR_W(ADDR_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we && lock_q && hit_mux),
    .idx       (mux_idx),
    .wr_val    (wr_legal),
    .rd_val    (mux_rd),
    .attr_flat (mux_attr),
    .upd       (mux_upd)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_lock)     bus_rdata[0]          = lock_q;
    else if (hit_ded) bus_rdata[ATTR_W-1:0] = ded_rd;
    else if (hit_mux) bus_rdata[ATTR_W-1:0] = mux_rd;
  end
endmodule

// File: rtl/padattr_bank_chk.sv
module padattr_bank_chk #(
  parameter int         NUM_DED   = 15,
  parameter int         NUM_MUX   = 32,
  parameter logic [7:0] ATTR_MASK = 8'h3F
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lock_q,
  input logic [NUM_DED*8-1:0]     ded_attr,
  input logic [NUM_DED-1:0]       ded_upd,
  input logic [NUM_MUX*8-1:0]     mux_attr,
  input logic [NUM_MUX-1:0]       mux_upd
);
  localparam int NUM_ALL = NUM_DED + NUM_MUX;
  localparam logic [7:0] UNIMPL = ~(ATTR_MASK & 8'h3F);

  logic [NUM_ALL*8-1:0] all_attr;
  logic [NUM_ALL-1:0]   all_upd;

  assign all_attr = {mux_attr, ded_attr};
  assign all_upd  = {mux_upd, ded_upd};

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q); // R2

  AST_NO_UPD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> (all_upd == '0)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_upd)); // R7

  for (genvar i = 0; i < NUM_ALL; i++) begin : g_pad
    AST_MOVE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !all_upd[i] |-> $stable(all_attr[i*8 +: 8])); // R7

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (all_attr[i*8 +: 8] & UNIMPL) == 8'h00); // R5

    AST_NO_PULL_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(all_attr[i*8+3] && all_attr[i*8+2])); // R6
  end
endmodule

bind padattr_bank padattr_bank_chk #(
  .NUM_DED   (NUM_DED),
  .NUM_MUX   (NUM_MUX),
  .ATTR_MASK (ATTR_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lock_q   (lock_q),
  .ded_attr (ded_attr),
  .ded_upd  (ded_upd),
  .mux_attr (mux_attr),
  .mux_upd  (mux_upd)
);

// File: tb/padattr_bank_tb.sv
`timescale 1ns/1ps
module padattr_bank_tb;
  localparam int ND = 15;
  localparam int NM = 32;
  localparam int AW = 8;
  localparam logic [7:0] MASK = 8'h3F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [ND*8-1:0] ded_attr;
  logic [ND-1:0]   ded_upd;
  logic [NM*8-1:0] mux_attr;
  logic [NM-1:0]   mux_upd;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  padattr_bank #(.NUM_DED(ND), .NUM_MUX(NM), .ADDR_W(AW), .ATTR_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ded_attr(ded_attr),
    .ded_upd(ded_upd), .mux_attr(mux_attr), .mux_upd(mux_upd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] raw);
    logic [7:0] v;
    v = raw & MASK & 8'h3F;
    if (v[3] && v[2]) v[2] = 1'b0;
    return v;
  endfunction

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_we = 1'b1; bus_wdata = data;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_we = 1'b0;
    #1 data = bus_rdata;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chk("R1 ded_attr", 64'(ded_attr == '0), 64'd1);
    chk("R1 mux_attr", 64'(mux_attr == '0), 64'd1);
    chk("R1 strobes", 64'({ded_upd, mux_upd} == '0), 64'd1);
    bus_read(0, d);  chk("R1 lock reads 1", 64'(d), 64'd1);
    bus_read(5, d);  chk("R1 ded readback", 64'(d), 64'd0);
    bus_read(30, d); chk("R1 mux readback", 64'(d), 64'd0);
  endtask

  task automatic test_ded_write(input int pad, input logic [31:0] data, input string req);
    logic [31:0] d;
    bus_write(1 + pad, data);
    chk({req, " ded byte"}, 64'(ded_attr[pad*8 +: 8]), 64'(model(data[7:0])));
    chk("R7 ded strobe", 64'(ded_upd), 64'(ND'(1) << pad));
    chk("R7 no mux strobe", 64'(mux_upd), 64'd0);
    @(posedge clk); #1;
    chk("R7 strobe one cycle", 64'(ded_upd), 64'd0);
    bus_read(1 + pad, d);
    chk("R8 ded readback", 64'(d), 64'(ded_attr[pad*8 +: 8]));
  endtask

  task automatic test_mux_write(input int pad, input logic [31:0] data);
    logic [31:0] d;
    bus_write(1 + ND + pad, data);
    chk("R4 mux byte", 64'(mux_attr[pad*8 +: 8]), 64'(model(data[7:0])));
    chk("R7 mux strobe", 64'(mux_upd), 64'(NM'(1) << pad));
    chk("R7 no ded strobe", 64'(ded_upd), 64'd0);
    bus_read(1 + ND + pad, d);
    chk("R4 mux readback", 64'(d), 64'(model(data[7:0])));
  endtask

  task automatic test_unmapped();
    logic [31:0] d;
    logic [ND*8-1:0] dsave;
    logic [NM*8-1:0] msave;
    dsave = ded_attr; msave = mux_attr;
    bus_write(1 + ND + NM, 32'hFFFF_FFFF);
    chk("R4 unmapped write no strobe", 64'({ded_upd, mux_upd} == '0), 64'd1);
    chk("R4 unmapped write no change", 64'((ded_attr == dsave) && (mux_attr == msave)), 64'd1);
    bus_read(1 + ND + NM, d); chk("R4 unmapped read", 64'(d), 64'd0);
    bus_read(200, d);         chk("R4 high unmapped read", 64'(d), 64'd0);
  endtask

  task automatic test_lock();
    logic [31:0] d;
    logic [7:0] old_m;
    bus_write(0, 32'h1);
    bus_read(0, d); chk("R2 write 1 keeps lock", 64'(d), 64'd1);
    old_m = mux_attr[5*8 +: 8];
    bus_write(0, 32'hFFFF_FFFE);
    bus_read(0, d); chk("R2 write 0 clears", 64'(d), 64'd0);
    bus_write(0, 32'h1);
    bus_read(0, d); chk("R2 sticky", 64'(d), 64'd0);
    bus_write(1 + ND + 5, 32'h21);
    chk("R3 no strobe locked", 64'({ded_upd, mux_upd} == '0), 64'd1);
    chk("R3 byte kept", 64'(mux_attr[5*8 +: 8]), 64'(old_m));
    bus_read(1 + ND + 5, d); chk("R3 readback kept", 64'(d), 64'(old_m));
    bus_write(1 + 3, 32'h10);
    chk("R3 ded kept", 64'(ded_attr[3*8 +: 8]), 64'h12);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_ded_write(0, 32'h0000_00FF, "R5");
    test_ded_write(1, 32'hABCD_00C5, "R5");
    test_ded_write(2, 32'h0000_000C, "R6");
    test_ded_write(4, 32'h0000_0004, "R6");
    test_ded_write(3, 32'h0000_0012, "R7");
    test_ded_write(ND - 1, 32'h0000_0030, "R4");
    test_mux_write(0, 32'h0000_0001);
    test_mux_write(5, 32'h0000_002A);
    test_mux_write(NM - 1, 32'h0000_00FE);
    test_unmapped();
    test_lock();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule